// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small accumulator processor that runs each instruction over several clock cycles and shares one memory port between instruction fetch and data access. Every instruction begins with a common fetch phase that latches the instruction word and advances the program counter by two through the ALU. It then spends one phase on decode, and after that a number of execute phases that depends on the opcode. An ALU result register and a memory data register hold values from one phase to the next. A single ALU therefore serves address arithmetic, operand arithmetic and the branch test.

The core drives an external word-wide memory with a byte address. Read data is expected back combinationally in the same cycle. Writes take effect on the following clock edge. The current phase, the program counter and the accumulator are brought out for observation. An instruction word carries the opcode in its upper byte and an 8-bit immediate or byte address in its lower byte.

Top module: `acc_mc_core`

## Requirements
- R1: While reset is active, and until the first fetch after it, the phase output is 0 (fetch), the program counter is 0 and the accumulator is 0. No memory write is issued in that time.
- R2: Phase encoding: fetch=0, decode=1, execute phases 2..5. In fetch the core reads memory at the program counter, latches the word as the instruction, and ends the phase with the program counter increased by 2, modulo 256.
- R3: The decode phase writes nothing: no memory write, and the accumulator and the program counter keep their values.
- R4: Opcode 0 (clear) sets the accumulator to 0 and takes 4 cycles, counting fetch.
- R5: Opcode 1 (add immediate) adds the zero-extended lower byte to the accumulator, modulo 2^16, and takes 4 cycles.
- R6: Opcode 2 (add from memory) adds the memory word at the byte address in the lower byte to the accumulator, modulo 2^16, and takes 6 cycles.
- R7: Opcode 3 (store) writes the accumulator to the byte address in the lower byte and takes 4 cycles. This is the only source of memory writes, and each store issues exactly one write, in its fourth phase.
- R8: Opcode 4 (branch if nonzero) takes 3 cycles. It loads the program counter with the lower byte when the accumulator is nonzero and leaves it at the fetch address plus 2 otherwise. The program counter changes only at the end of fetch or of this branch phase.
- R9: The phase always goes from fetch to decode, and after the last phase of an instruction back to fetch. It never exceeds 5.
- R10: Any opcode from 5 to 255 is treated as a no-operation: the core returns to fetch right after decode (2 cycles) and changes neither the accumulator nor memory.
- R11: Memory is addressed by byte, with word index = address / 2. The fetch reads at the program counter. A data read or write uses the lower instruction byte, which is passed through the ALU result register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| mem_addr | output | 8 | Byte address to the unified memory |
| mem_rd | output | 1 | Memory read strobe (fetch or data load) |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Combinational read data from memory |
| phase_o | output | 3 | Current phase, 0 = fetch ... 5 = last add phase |
| pc_o | output | 8 | Program counter |
| acc_o | output | 16 | Accumulator |

## Verification
The bound checker watches the phase ordering on every cycle. It also checks that fetch drives the program counter onto the address lines and steps it by two, and that decode writes nothing. Further per-cycle checks confine program counter changes to fetch and the branch phase, accumulator changes to the end of the fourth or sixth phase, and memory writes to the fourth phase. Only the scenario bench can show that each opcode produces the right arithmetic value and takes the right number of cycles. The same holds for branch-taken versus not-taken targets, wrap-around in the adder, and store-then-load through memory. The bench compares these against an instruction-level model of the program.

// File: rtl/acc_mc_pkg.sv
package acc_mc_pkg;

  localparam int unsigned OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_CLEAR = 8'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 8'd1;
  localparam logic [OPC_W-1:0] OPC_ADDM  = 8'd2;
  localparam logic [OPC_W-1:0] OPC_STORE = 8'd3;
  localparam logic [OPC_W-1:0] OPC_BNZ   = 8'd4;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EX1    = 3'd2,
    PH_EX2    = 3'd3,
    PH_EX3    = 3'd4,
    PH_EX4    = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    ALU_NONE  = 3'd0,
    ALU_XPASS = 3'd1,
    ALU_SUB   = 3'd2,
    ALU_YPASS = 3'd3,
    ALU_ZERO  = 3'd4,
    ALU_ADD   = 3'd5
  } alu_op_e;

  typedef enum logic {
    XS_PC  = 1'b0,
    XS_ACC = 1'b1
  } x_sel_e;

  typedef enum logic [1:0] {
    YS_TWO = 2'd0,
    YS_MDR = 2'd1,
    YS_IMM = 2'd2
  } y_sel_e;

  typedef struct packed {
    logic    p0;
    logic    bz;
    logic    pc_from_imm;
    logic    ir_we;
    logic    mdr_we;
    logic    aout_we;
    logic    acc_we;
    logic    mem_rd;
    logic    mem_wr;
    logic    data_addr;
    x_sel_e  x_sel;
    y_sel_e  y_sel;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/acc_mc_rst_sync.sv
module acc_mc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/acc_mc_alu.sv
module acc_mc_alu
  import acc_mc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] res,
  output logic         zero
);

  always_comb begin
    unique case (op)
      ALU_XPASS: res = x;
      ALU_SUB:   res = x - y;
      ALU_YPASS: res = y;
      ALU_ADD:   res = x + y;
      default:   res = '0;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/acc_mc_ctrl.sv
module acc_mc_ctrl
  import acc_mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctl,
  output phase_e           phase
);

  phase_e phase_q, phase_d;
  logic   opc_known;

  assign opc_known = (opcode == OPC_CLEAR) || (opcode == OPC_ADDI) ||
                     (opcode == OPC_ADDM)  || (opcode == OPC_STORE) ||
                     (opcode == OPC_BNZ);

  // next-phase selection
  always_comb begin
    phase_d = PH_FETCH;
    unique case (phase_q)
      PH_FETCH:  phase_d = PH_DECODE;
      PH_DECODE: phase_d = opc_known ? PH_EX1 : PH_FETCH;
      PH_EX1:    phase_d = (opcode == OPC_BNZ) ? PH_FETCH : PH_EX2;
      PH_EX2:    phase_d = (opcode == OPC_ADDM) ? PH_EX3 : PH_FETCH;
      PH_EX3:    phase_d = PH_EX4;
      default:   phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
    end else begin
      phase_q <= phase_d;
    end
  end

  // per-phase control word
  always_comb begin
    ctl        = '0;
    ctl.x_sel  = XS_ACC;
    ctl.y_sel  = YS_IMM;
    ctl.alu_op = ALU_NONE;
    unique case (phase_q)
      PH_FETCH: begin
        ctl.ir_we  = 1'b1;
        ctl.mem_rd = 1'b1;
        ctl.x_sel  = XS_PC;
        ctl.y_sel  = YS_TWO;
        ctl.alu_op = ALU_ADD;
        ctl.p0     = 1'b1;
      end
      PH_EX1: begin
        if (opcode == OPC_CLEAR) begin
          ctl.alu_op  = ALU_ZERO;
          ctl.aout_we = 1'b1;
        end else if (opcode == OPC_ADDI) begin
          ctl.alu_op  = ALU_ADD;
          ctl.aout_we = 1'b1;
        end else if (opcode == OPC_ADDM || opcode == OPC_STORE) begin
          ctl.alu_op  = ALU_YPASS;
          ctl.aout_we = 1'b1;
        end else if (opcode == OPC_BNZ) begin
          ctl.alu_op      = ALU_XPASS;
          ctl.bz          = 1'b1;
          ctl.pc_from_imm = 1'b1;
        end
      end
      PH_EX2: begin
        if (opcode == OPC_CLEAR || opcode == OPC_ADDI) begin
          ctl.acc_we = 1'b1;
        end else if (opcode == OPC_ADDM) begin
          ctl.data_addr = 1'b1;
          ctl.mem_rd    = 1'b1;
          ctl.mdr_we    = 1'b1;
        end else if (opcode == OPC_STORE) begin
          ctl.data_addr = 1'b1;
          ctl.mem_wr    = 1'b1;
        end
      end
      PH_EX3: begin
        ctl.y_sel   = YS_MDR;
        ctl.alu_op  = ALU_ADD;
        ctl.aout_we = 1'b1;
      end
      PH_EX4: begin
        ctl.acc_we = 1'b1;
      end
      default: ;
    endcase
  end

  assign phase = phase_q;

endmodule

// File: rtl/acc_mc_dpath.sv
module acc_mc_dpath
  import acc_mc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctrl_t                      ctl,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  output logic [DATA_W-ADDR_W-1:0]   opcode,
  output logic [ADDR_W-1:0]          pc,
  output logic [DATA_W-1:0]          acc
);

  localparam int unsigned EXT_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] ir_q, mdr_q, aout_q, acc_q;
  logic [DATA_W-1:0] alu_x, alu_y, alu_res;
  logic [ADDR_W-1:0] imm;
  logic              alu_zero;
  logic              pc_we;

  assign imm    = ir_q[ADDR_W-1:0];
  assign opcode = ir_q[DATA_W-1:ADDR_W];

  // operand selection
  always_comb begin
    unique case (ctl.x_sel)
      XS_PC:   alu_x = {{EXT_W{1'b0}}, pc_q};
      default: alu_x = acc_q;
    endcase
    unique case (ctl.y_sel)
      YS_TWO:  alu_y = DATA_W'(2);
      YS_MDR:  alu_y = mdr_q;
      default: alu_y = {{EXT_W{1'b0}}, imm};
    endcase
  end

  acc_mc_alu #(.W(DATA_W)) u_alu (
    .op   (ctl.alu_op),
    .x    (alu_x),
    .y    (alu_y),
    .res  (alu_res),
    .zero (alu_zero)
  );

  // program counter write: unconditional step or branch on nonzero
  assign pc_we = ctl.p0 | (~alu_zero & ctl.bz);
  assign pc_d  = ctl.pc_from_imm ? imm : alu_res[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_we) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
    end else if (ctl.ir_we) begin
      ir_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdr_q <= '0;
    end else if (ctl.mdr_we) begin
      mdr_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aout_q <= '0;
    end else if (ctl.aout_we) begin
      aout_q <= alu_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (ctl.acc_we) begin
      acc_q <= aout_q;
    end
  end

  // address select: instruction fetch or data access
  assign mem_addr  = ctl.data_addr ? aout_q[ADDR_W-1:0] : pc_q;
  assign mem_wdata = acc_q;
  assign pc        = pc_q;
  assign acc       = acc_q;

endmodule

// File: rtl/acc_mc_core.sv
module acc_mc_core
  import acc_mc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [2:0]        phase_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o
);

  localparam int unsigned OP_FIELD_W = DATA_W - ADDR_W;

  logic                  core_rst_n;
  ctrl_t                 ctl;
  phase_e                phase;
  logic [OP_FIELD_W-1:0] opcode;

  acc_mc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  acc_mc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .opcode (OPC_W'(opcode)),
    .ctl    (ctl),
    .phase  (phase)
  );

  acc_mc_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .opcode    (opcode),
    .pc        (pc_o),
    .acc       (acc_o)
  );

  assign mem_rd  = ctl.mem_rd;
  assign mem_wr  = ctl.mem_wr;
  assign phase_o = phase;

endmodule

// File: rtl/acc_mc_core_chk.sv
module acc_mc_core_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        phase,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr
);

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (phase == 3'd0 && pc == '0 && acc == '0 && !mem_wr)); // R1

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd0 |=> pc == ADDR_W'($past(pc) + ADDR_W'(2))); // R2

  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd0 |-> (mem_rd && !mem_wr && mem_addr == pc)); // R11

  AST_DECODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd1 |=> ($stable(pc) && $stable(acc) && !$past(mem_wr))); // R3

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd0 |=> phase == 3'd1); // R9

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd5); // R9

  AST_LAST_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd5 |=> phase == 3'd0); // R6

  AST_WRITE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (phase == 3'd3 && !mem_rd)); // R7

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd3 && phase != 3'd5) |=> $stable(acc)); // R4

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd0 && phase != 3'd2) |=> $stable(pc)); // R8

endmodule

bind acc_mc_core acc_mc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (core_rst_n),
  .phase    (phase_o),
  .pc       (pc_o),
  .acc      (acc_o),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr)
);

// File: tb/acc_mc_core_test.sv
`timescale 1ns/1ps
module acc_mc_core_test;

  localparam int NINSN = 24;

  logic        clk;
  logic        rst_n;
  logic [7:0]  mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [2:0]  phase_o;
  logic [7:0]  pc_o;
  logic [15:0] acc_o;

  acc_mc_core uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .phase_o   (phase_o),
    .pc_o      (pc_o),
    .acc_o     (acc_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory model: byte address, word index = address / 2
  logic [15:0] mem [128];
  assign mem_rdata = mem[mem_addr[7:1]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:1]] <= mem_wdata;

  typedef struct {
    logic [7:0]  pc;
    logic [15:0] acc;
    int          dur;
    int          req;
    int          pc_req;
  } dec_item_t;

  typedef struct {
    logic [7:0]  addr;
    logic [15:0] data;
  } wr_item_t;

  dec_item_t dec_q[$];
  wr_item_t  wr_q[$];

  int  total = 0;
  int  bad   = 0;
  int  seen  = 0;
  int  cnt   = 0;
  bit  done  = 0;

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(input logic [7:0] op, input logic [7:0] arg);
    return {op, arg};
  endfunction

  // driver: loads the program and pushes the instruction-level predictions
  task automatic drive_program();
    logic [15:0] rm [128];
    logic [7:0]  rpc;
    logic [15:0] racc;
    int          pdur, preq, ppcreq;
    for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
    mem[0]  = ins(8'd0, 8'h00);   // clear            R4
    mem[1]  = ins(8'd1, 8'h05);   // addi 5           R5
    mem[2]  = ins(8'd3, 8'h80);   // store 0x80       R7
    mem[3]  = ins(8'd2, 8'h80);   // add [0x80]       R6 (reads back store)
    mem[4]  = ins(8'd2, 8'h82);   // add [0x82]       R6
    mem[5]  = ins(8'd1, 8'hFF);   // addi 255         R5
    mem[6]  = ins(8'd4, 8'h10);   // bnz 0x10 taken   R8
    mem[7]  = ins(8'd1, 8'h01);   // skipped
    mem[8]  = ins(8'd0, 8'h00);   // clear
    mem[9]  = ins(8'd4, 8'h0E);   // bnz not taken    R8
    mem[10] = ins(8'd7, 8'h00);   // unknown opcode   R10
    mem[11] = ins(8'hFF, 8'h12);  // unknown opcode   R10
    mem[12] = ins(8'd2, 8'h84);   // add [0x84]
    mem[13] = ins(8'd1, 8'h02);   // addi 2, wraps    R5
    mem[14] = ins(8'd3, 8'h86);   // store 0x86       R7
    mem[15] = ins(8'd4, 8'h1E);   // bnz to itself    R8
    mem[65] = 16'h1234;
    mem[66] = 16'hFFFF;
    for (int i = 0; i < 128; i++) rm[i] = mem[i];
    rpc = 8'h00; racc = 16'h0000; pdur = -1; preq = 1; ppcreq = 1;
    for (int n = 0; n < NINSN; n++) begin
      logic [15:0] w;
      rpc = rpc + 8'd2;
      dec_q.push_back('{pc: rpc, acc: racc, dur: pdur, req: preq, pc_req: ppcreq});
      w = rm[(rpc - 8'd2) >> 1];
      ppcreq = 2;
      case (w[15:8])
        8'd0: begin racc = 16'h0000; pdur = 4; preq = 4; end
        8'd1: begin racc = racc + {8'h00, w[7:0]}; pdur = 4; preq = 5; end
        8'd2: begin racc = racc + rm[w[7:1]]; pdur = 6; preq = 6; end
        8'd3: begin
          rm[w[7:1]] = racc;
          wr_q.push_back('{addr: w[7:0], data: racc});
          pdur = 4; preq = 7;
        end
        8'd4: begin
          if (racc != 16'h0000) rpc = w[7:0];
          pdur = 3; preq = 8; ppcreq = 8;
        end
        default: begin pdur = 2; preq = 10; end
      endcase
    end
  endtask

  // monitor: pops predictions as the core reaches decode and as writes appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (phase_o == 3'd1) begin
        if (dec_q.size() == 0) begin
          chk(1'b0, 9, "unexpected decode", 32'(pc_o), 32'hFFFF);
        end else begin
          dec_item_t it;
          it = dec_q.pop_front();
          chk(pc_o == it.pc, it.pc_req, "pc at decode", 32'(pc_o), 32'(it.pc));
          chk(acc_o == it.acc, it.req, "acc at decode", 32'(acc_o), 32'(it.acc));
          if (it.dur > 0)
            chk(cnt == it.dur, it.req, "cycles per instruction", 32'(cnt), 32'(it.dur));
        end
        cnt = 1;
        seen++;
        if (seen == NINSN) done = 1;
      end else begin
        cnt++;
      end
      if (mem_wr) begin
        if (wr_q.size() == 0) begin
          chk(1'b0, 7, "unexpected write", 32'(mem_addr), 32'hFFFF);
        end else begin
          wr_item_t wi;
          wi = wr_q.pop_front();
          chk(mem_addr == wi.addr, 7, "store address", 32'(mem_addr), 32'(wi.addr));
          chk(mem_wdata == wi.data, 7, "store data", 32'(mem_wdata), 32'(wi.data));
        end
      end
    end
  end

  initial begin
    int cyc;
    rst_n = 1'b0;
    drive_program();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(phase_o == 3'd0, 1, "reset phase", 32'(phase_o), 32'd0);
    chk(pc_o == 8'h00, 1, "reset pc", 32'(pc_o), 32'd0);
    chk(acc_o == 16'h0000, 1, "reset acc", 32'(acc_o), 32'd0);
    chk(mem_wr == 1'b0, 1, "reset write strobe", 32'(mem_wr), 32'd0);
    rst_n = 1'b1;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) chk(1'b0, 9, "watchdog, decodes seen", 32'(seen), 32'(NINSN));
    @(negedge clk);
    // R7: every predicted store was observed
    chk(wr_q.size() == 0, 7, "pending stores", 32'(wr_q.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule